// File: doc/BRIEF.md
# Radio Operating-Mode Sequencer

This block turns three static control pins of a radio front end into one of four operating modes: power-off, idle, receiving and transmitting. It then drives one enable line per analog sub-block. Each line is gated by a bit of a block-enable word held elsewhere on the chip, so software can keep any sub-block off. A stuck-on enable is therefore impossible without software consent.

The block also times the settling that follows a mode change, with every duration given as a parameter in clock cycles. On entering receive, it counts out a DC-offset settling window before it raises a receive-ready flag. On entering transmit, it runs three phases in order:

1. A calibration window, during which the transmit data source must hold a zero differential value.
2. A driver-gain ramp, in which a 4-bit gain code climbs from 0 to 15 in equal steps.
3. Transmit-ready.

Leaving the active mode at any moment ends the sequence on the same clock edge.

FSM states are `ST_OFF`, `ST_IDLE`, `ST_RX_SETTLE`, `ST_RX_READY`, `ST_TX_CAL`, `ST_TX_RAMP` and `ST_TX_READY`. Their transitions are:

- Power-off mode forces any state to `ST_OFF`.
- Idle mode forces any state to `ST_IDLE`.
- Receive mode moves a non-receive state to `ST_RX_SETTLE`. `ST_RX_SETTLE` moves to `ST_RX_READY` when the settle count ends.
- Transmit mode moves a non-transmit state to `ST_TX_CAL`. `ST_TX_CAL` moves to `ST_TX_RAMP` when the calibration count ends. `ST_TX_RAMP` moves to `ST_TX_READY` on the step that brings the gain code to 15.

Top module: `trx_mode_seq`

## Requirements
- R1: The `mode` output is updated on the first clock edge after the pins change. Low `shdn_n` gives 0 (power-off). High `shdn_n` with both `rx_on` and `tx_on` low gives 1 (idle). Only `rx_on` high gives 2 (receive). Only `tx_on` high gives 3 (transmit).
- R2: `en_out` bits 0 to 3 (synthesizer, oscillator, LO chain, filter tuner) follow `blk_en` in modes 1, 2 and 3. Bit 4 (receive path) follows `blk_en` only in mode 2. Bit 5 (transmit path) follows `blk_en` only in mode 3. In mode 0 every bit is 0. `blk_en` acts without a clock delay.
- R3: With `shdn_n` high, `rx_on` and `tx_on` both high is illegal and gives mode 1, with no ready flag, no calibration and a gain code of 0.
- R4: `rx_ready` rises on the edge RX_SETTLE_CYC cycles after the edge that first registers mode 2. It stays high while mode 2 lasts and is low in every other mode.
- R5: `cal_active` is high for exactly TX_CAL_CYC cycles, starting on the edge that first registers mode 3. The gain code is 0 throughout that window.
- R6: After calibration, `pa_gain` starts at 0 and rises by one every STEP cycles, where STEP = max(1, TX_RAMP_CYC/15). It stops at 15.
- R7: `tx_ready` rises on the same edge on which `pa_gain` reaches 15. It stays high with `pa_gain` at 15 while mode 3 lasts.
- R8: On the edge that registers a mode other than the running one, `rx_ready`, `tx_ready` and `cal_active` clear and `pa_gain` returns to 0.
- R9: A direct change from receive to transmit restarts the transmit sequence at calibration. A direct change from transmit to receive restarts the receive settling from zero.
- R10: While `rst_n` is low, `mode` is 0 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low power-down pin |
| rx_on | input | 1 | Receive request pin |
| tx_on | input | 1 | Transmit request pin |
| blk_en | input | 6 | Block-enable word, one bit per sub-block |
| mode | output | 2 | Registered operating mode (0 off, 1 idle, 2 receive, 3 transmit) |
| en_out | output | 6 | Qualified sub-block enables |
| rx_ready | output | 1 | Receive path settled |
| tx_ready | output | 1 | Transmit path at full gain |
| cal_active | output | 1 | Transmit offset calibration under way |
| pa_gain | output | 4 | Driver gain ramp code |

## Verification
The `mode` output and the three flags are due on the first clock edge after a pin change. `en_out` is due combinationally from `blk_en`. `rx_ready` is due RX_SETTLE_CYC edges after mode 2 is registered. `pa_gain` is due at TX_CAL_CYC + n·STEP edges after mode 3 is registered, and `tx_ready` with n = 15.

The bench drives pins 1 ns after a rising edge, so the design sees them on the next edge. Its reference model counts cycles since mode entry and is compared at each falling edge. Directed checks are placed at the edge just before and the edge of each expected transition, so an off-by-one in any counter is caught.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

    localparam int NUM_BLK = 6;
    localparam int GAIN_W  = 4;
    localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

    // bit positions inside the block-enable word
    localparam int BLK_SYNTH = 0;
    localparam int BLK_OSC   = 1;
    localparam int BLK_LO    = 2;
    localparam int BLK_TUNE  = 3;
    localparam int BLK_RX    = 4;
    localparam int BLK_TX    = 5;

    typedef enum logic [1:0] {
        MODE_SHUT = 2'd0,
        MODE_STBY = 2'd1,
        MODE_RX   = 2'd2,
        MODE_TX   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_RX_SETTLE,
        ST_RX_READY,
        ST_TX_CAL,
        ST_TX_RAMP,
        ST_TX_READY
    } seq_state_e;

endpackage

// File: rtl/trx_mode_decode.sv
module trx_mode_decode
    import trx_mode_pkg::*;
(
    input  logic  shdn_n,
    input  logic  rx_on,
    input  logic  tx_on,
    output mode_e mode_d
);

    always_comb begin
        if (!shdn_n)
            mode_d = MODE_SHUT;
        else if (rx_on && !tx_on)
            mode_d = MODE_RX;
        else if (tx_on && !rx_on)
            mode_d = MODE_TX;
        else
            mode_d = MODE_STBY;   // idle, or both requests raised together
    end

endmodule

// File: rtl/trx_enable_gate.sv
module trx_enable_gate
    import trx_mode_pkg::*;
(
    input  mode_e              mode,
    input  logic [NUM_BLK-1:0] blk_en,
    output logic [NUM_BLK-1:0] en_out
);

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
        if (i == BLK_RX) begin : g_rx
            assign en_out[i] = blk_en[i] & (mode == MODE_RX);
        end else if (i == BLK_TX) begin : g_tx
            assign en_out[i] = blk_en[i] & (mode == MODE_TX);
        end else begin : g_common
            assign en_out[i] = blk_en[i] & (mode != MODE_SHUT);
        end
    end

endmodule

// File: rtl/trx_seq_fsm.sv
module trx_seq_fsm
    import trx_mode_pkg::*;
#(
    parameter int RX_SETTLE_CYC = 2500,
    parameter int TX_CAL_CYC    = 550,
    parameter int TX_RAMP_CYC   = 375
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_d,
    output logic              rx_ready,
    output logic              tx_ready,
    output logic              cal_active,
    output logic [GAIN_W-1:0] gain
);

    localparam int STEP_RAW = TX_RAMP_CYC / int'(GAIN_MAX);
    localparam int STEP_CYC = (STEP_RAW < 1) ? 1 : STEP_RAW;
    localparam int MAX_A    = (RX_SETTLE_CYC > TX_CAL_CYC) ? RX_SETTLE_CYC : TX_CAL_CYC;
    localparam int MAX_CNT  = (MAX_A > STEP_CYC) ? MAX_A : STEP_CYC;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);

    localparam logic [CNT_W-1:0] LAST_RX   = CNT_W'(RX_SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_CAL  = CNT_W'(TX_CAL_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEP_CYC - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [GAIN_W-1:0] gain_q, gain_d;
    logic              in_rx, in_tx;

    assign in_rx = (state_q == ST_RX_SETTLE) || (state_q == ST_RX_READY);
    assign in_tx = (state_q == ST_TX_CAL) || (state_q == ST_TX_RAMP) ||
                   (state_q == ST_TX_READY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            gain_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gain_q  <= gain_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_W'(1);
        gain_d  = gain_q;
        unique case (mode_d)
            MODE_SHUT: begin
                state_d = ST_OFF;
                cnt_d   = '0;
                gain_d  = '0;
            end
            MODE_STBY: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
                gain_d  = '0;
            end
            MODE_RX: begin
                gain_d = '0;
                if (!in_rx) begin
                    state_d = ST_RX_SETTLE;
                    cnt_d   = '0;
                end else if (state_q == ST_RX_READY) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST_RX) begin
                    state_d = ST_RX_READY;
                    cnt_d   = '0;
                end
            end
            MODE_TX: begin
                if (!in_tx) begin
                    state_d = ST_TX_CAL;
                    cnt_d   = '0;
                    gain_d  = '0;
                end else begin
                    unique case (state_q)
                        ST_TX_CAL: begin
                            if (cnt_q == LAST_CAL) begin
                                state_d = ST_TX_RAMP;
                                cnt_d   = '0;
                            end
                        end
                        ST_TX_RAMP: begin
                            if (cnt_q == LAST_STEP) begin
                                cnt_d  = '0;
                                gain_d = gain_q + GAIN_W'(1);
                                if (gain_q == GAIN_MAX - GAIN_W'(1))
                                    state_d = ST_TX_READY;
                            end
                        end
                        default: begin
                            cnt_d = '0;
                        end
                    endcase
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        rx_ready   = (state_q == ST_RX_READY);
        tx_ready   = (state_q == ST_TX_READY);
        cal_active = (state_q == ST_TX_CAL);
        gain       = gain_q;
    end

endmodule

// File: rtl/trx_mode_seq.sv
module trx_mode_seq
    import trx_mode_pkg::*;
#(
    parameter int RX_SETTLE_CYC = 2500,
    parameter int TX_CAL_CYC    = 550,
    parameter int TX_RAMP_CYC   = 375
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn_n,
    input  logic               rx_on,
    input  logic               tx_on,
    input  logic [NUM_BLK-1:0] blk_en,
    output logic [1:0]         mode,
    output logic [NUM_BLK-1:0] en_out,
    output logic               rx_ready,
    output logic               tx_ready,
    output logic               cal_active,
    output logic [GAIN_W-1:0]  pa_gain
);

    mode_e mode_d, mode_q;

    trx_mode_decode u_decode (
        .shdn_n (shdn_n),
        .rx_on  (rx_on),
        .tx_on  (tx_on),
        .mode_d (mode_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SHUT;
        else        mode_q <= mode_d;
    end

    trx_seq_fsm #(
        .RX_SETTLE_CYC (RX_SETTLE_CYC),
        .TX_CAL_CYC    (TX_CAL_CYC),
        .TX_RAMP_CYC   (TX_RAMP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_d     (mode_d),
        .rx_ready   (rx_ready),
        .tx_ready   (tx_ready),
        .cal_active (cal_active),
        .gain       (pa_gain)
    );

    trx_enable_gate u_gate (
        .mode   (mode_q),
        .blk_en (blk_en),
        .en_out (en_out)
    );

    assign mode = mode_q;

endmodule

// File: rtl/trx_mode_seq_chk.sv
module trx_mode_seq_chk
    import trx_mode_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               shdn_n,
    input logic               rx_on,
    input logic               tx_on,
    input logic [1:0]         mode,
    input logic [NUM_BLK-1:0] en_out,
    input logic               rx_ready,
    input logic               tx_ready,
    input logic               cal_active,
    input logic [GAIN_W-1:0]  pa_gain
);

    // R2
    shut_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (en_out == '0));

    // R2
    paths_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_out[BLK_RX] && en_out[BLK_TX]));

    // R3
    illegal_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && rx_on && tx_on) |=> (mode == 2'd1));

    // R4
    rx_ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (mode == 2'd2));

    // R5
    cal_gain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (pa_gain == '0 && !tx_ready && mode == 2'd3));

    // R6
    gain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_gain == '0) |=> (pa_gain <= GAIN_W'(1)));

    // R6
    gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_gain != '0) |=> (pa_gain == '0 || pa_gain == $past(pa_gain) ||
                             pa_gain == $past(pa_gain) + GAIN_W'(1)));

    // R7
    tx_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (pa_gain == GAIN_MAX && mode == 2'd3));

    // R8
    leave_tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd3) |-> (pa_gain == '0 && !cal_active && !tx_ready));

endmodule

bind trx_mode_seq trx_mode_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_n     (shdn_n),
    .rx_on      (rx_on),
    .tx_on      (tx_on),
    .mode       (mode),
    .en_out     (en_out),
    .rx_ready   (rx_ready),
    .tx_ready   (tx_ready),
    .cal_active (cal_active),
    .pa_gain    (pa_gain)
);

// File: tb/trx_mode_seq_bench.sv
`timescale 1ns/1ps
module trx_mode_seq_bench;

    localparam int RXN  = 40;
    localparam int CAL  = 12;
    localparam int RAMP = 30;
    localparam int STEP = (RAMP / 15 < 1) ? 1 : RAMP / 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b0;
    logic       rx_on = 1'b0;
    logic       tx_on = 1'b0;
    logic [5:0] blk_en = 6'h3F;
    logic [1:0] mode;
    logic [5:0] en_out;
    logic       rx_ready, tx_ready, cal_active;
    logic [3:0] pa_gain;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trx_mode_seq #(
        .RX_SETTLE_CYC (RXN),
        .TX_CAL_CYC    (CAL),
        .TX_RAMP_CYC   (RAMP)
    ) u_trx_mode_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .rx_on      (rx_on),
        .tx_on      (tx_on),
        .blk_en     (blk_en),
        .mode       (mode),
        .en_out     (en_out),
        .rx_ready   (rx_ready),
        .tx_ready   (tx_ready),
        .cal_active (cal_active),
        .pa_gain    (pa_gain)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // reference model: mode and cycles spent in it
    int m_mode = 0;
    int rx_t = 0;
    int tx_t = 0;
    int nm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; rx_t = 0; tx_t = 0;
        end else begin
            if (!shdn_n)                nm = 0;
            else if (rx_on && !tx_on)   nm = 2;
            else if (tx_on && !rx_on)   nm = 3;
            else                        nm = 1;
            rx_t = (nm == 2 && m_mode == 2) ? rx_t + 1 : 0;
            tx_t = (nm == 3 && m_mode == 3) ? tx_t + 1 : 0;
            m_mode = nm;
        end
    end

    function automatic int exp_gain();
        int g;
        if (m_mode != 3 || tx_t < CAL) return 0;
        g = (tx_t - CAL) / STEP;
        return (g > 15) ? 15 : g;
    endfunction

    function automatic int exp_en();
        int e;
        e = 0;
        if (m_mode != 0) e = blk_en & 6'h0F;
        if (m_mode == 2) e = e | (blk_en & 6'h10);
        if (m_mode == 3) e = e | (blk_en & 6'h20);
        return e;
    endfunction

    always @(negedge clk) begin
        chk("R1 mode", mode, m_mode);
        chk("R2 en_out", en_out, exp_en());
        chk("R4 rx_ready", rx_ready, (m_mode == 2 && rx_t >= RXN) ? 1 : 0);
        chk("R5 cal_active", cal_active, (m_mode == 3 && tx_t < CAL) ? 1 : 0);
        chk("R6 pa_gain", pa_gain, exp_gain());
        chk("R7 tx_ready", tx_ready, (m_mode == 3 && tx_t >= CAL + 15 * STEP) ? 1 : 0);
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R10 reset state
        chk("R10 mode", mode, 0);
        chk("R10 en_out", en_out, 0);
        chk("R10 flags", {rx_ready, tx_ready, cal_active}, 0);
        chk("R10 gain", pa_gain, 0);
        rst_n = 1'b1;
        tick();
        shdn_n = 1'b1;
        tick();
        chk("R1 idle", mode, 1);
        chk("R2 idle en", en_out, 6'h0F);
        blk_en = 6'b110101;
        tick();
        chk("R2 masked", en_out, 6'b000101);
        blk_en = 6'h3F;
        rx_on = 1'b1;
        tick();
        chk("R1 rx", mode, 2);
        chk("R2 rx en", en_out, 6'h1F);
        repeat (RXN - 1) tick();
        chk("R4 before", rx_ready, 0);
        tick();
        chk("R4 ready", rx_ready, 1);
        rx_on = 1'b0;
        tick();
        chk("R8 rx abort", rx_ready, 0);
        // transmit, abort mid ramp
        tx_on = 1'b1;
        tick();
        chk("R5 cal start", cal_active, 1);
        repeat (CAL - 1) tick();
        chk("R5 cal last", cal_active, 1);
        tick();
        chk("R5 cal end", cal_active, 0);
        chk("R6 ramp start", pa_gain, 0);
        repeat (STEP) tick();
        chk("R6 step1", pa_gain, 1);
        repeat (4 * STEP) tick();
        chk("R6 step5", pa_gain, 5);
        tx_on = 1'b0;
        tick();
        chk("R8 gain cleared", pa_gain, 0);
        chk("R8 mode", mode, 1);
        // full transmit sequence
        tx_on = 1'b1;
        repeat (CAL + 15 * STEP) tick();
        chk("R7 before", tx_ready, 0);
        chk("R6 gain14", pa_gain, 14);
        tick();
        chk("R7 ready", tx_ready, 1);
        chk("R7 gain15", pa_gain, 15);
        chk("R2 tx en", en_out, 6'h2F);
        // R3 illegal combination
        rx_on = 1'b1;
        tick();
        chk("R3 mode", mode, 1);
        chk("R3 ready", tx_ready, 0);
        chk("R3 gain", pa_gain, 0);
        chk("R3 en", en_out, 6'h0F);
        // R9 direct switches
        tx_on = 1'b0;
        repeat (RXN + 1) tick();
        chk("R9 rx ready", rx_ready, 1);
        rx_on = 1'b0; tx_on = 1'b1;
        tick();
        chk("R9 to tx mode", mode, 3);
        chk("R9 cal", cal_active, 1);
        chk("R9 rx cleared", rx_ready, 0);
        repeat (CAL + 3 * STEP) tick();
        rx_on = 1'b1; tx_on = 1'b0;
        tick();
        chk("R9 to rx mode", mode, 2);
        chk("R9 rx restart", rx_ready, 0);
        chk("R9 gain", pa_gain, 0);
        // power-down mid receive
        repeat (10) tick();
        shdn_n = 1'b0;
        tick();
        chk("R1 off", mode, 0);
        chk("R2 off en", en_out, 0);
        shdn_n = 1'b1;
        tick();
        chk("R4 restart", rx_ready, 0);
        repeat (RXN) tick();
        chk("R4 ready again", rx_ready, 1);
        rx_on = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule